// File: doc/BRIEF.md
# Host-to-Controller Command Mailbox

This block is a memory-mapped mailbox between a host processor and a power-management microcontroller. The host fills a 16-byte outgoing payload buffer and two 32-bit pointer words. It then writes a packed command word that holds a command code, a sub-command, a byte length and an interrupt-request flag. That write sets the busy bit and sends a one-cycle doorbell to the controller. With the doorbell come the latched command, both pointers and the full payload.

The controller can fill up to four reply words at any time. It ends the transaction with a completion pulse, and the pulse returns an error flag and an 8-bit error code. The host can learn of completion in two ways. It can poll the status word until busy drops. Or it can ask for an interrupt in the command word and wait on the level interrupt line. It acknowledges the interrupt by writing the status word with the completion bit set.

Error codes 0 to 7 are: no error, unsupported command, command not serviced, unable to service, invalid command, command failed, security rejection and unsigned-image rejection. The mailbox carries the code through to the host and does not interpret it.

Top module: `ipc_mailbox`

## Requirements
- R1: After reset every register is zero: the status word reads 0x0, the command word reads 0x0, `host_irq` and `bell_valid` are low, and `host_rdata` is 0.
- R2: A host write to offset 0x00 while busy is clear has these effects. The word is latched as the command and the busy bit (status bit 0) is set. In the following cycle `bell_valid` is high for exactly one cycle, and `bell_cmd`, `bell_sptr`, `bell_dptr` and `bell_payload` show the command, the two pointers and the four payload words (word i at bits 32i+31:32i).
- R3: A command write while busy is set is ignored. It raises no doorbell and leaves the latched command unchanged.
- R4: A `ctl_done` pulse while busy does three things. It clears busy, it sets the completion flag (status bit 2), and it captures `ctl_err` into status bit 1 and `ctl_code` into status bits 23:16. A `ctl_done` pulse while idle has no effect.
- R5: An accepted command clears the error bit and the error code, so status reads 0x00000001 right after a new command.
- R6: `host_irq` is high exactly when the completion flag is set and bit 8 of the latched command is set. A command issued with bit 8 clear never raises it.
- R7: A host write to status with bit 2 set clears the completion flag. A status write with bit 2 clear leaves the flag alone. If a completion and a clearing write fall in the same cycle, the flag ends up set.
- R8: The source pointer at 0x08, the destination pointer at 0x0C and payload word i at 0x80+4i can be written and read back by the host. The command word reads back at 0x00.
- R9: When `ctl_reply_we` is high, `ctl_reply_data` is stored in reply word `ctl_reply_idx`. The host reads reply word i at 0x90+4i.
- R10: Some offsets are unmapped: anything not listed above, and any address whose bits 1:0 are non-zero. Host reads of them return 0. Host writes to them, or to the reply buffer, change nothing.
- R11: `host_rdata` takes the addressed value in the cycle after `host_rd` is sampled high and holds it until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_addr | input | ADDR_W | Host byte address |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Registered host read data |
| host_irq | output | 1 | Level completion interrupt to the host |
| bell_valid | output | 1 | One-cycle doorbell to the controller |
| bell_cmd | output | 32 | Latched command word |
| bell_sptr | output | 32 | Source pointer word |
| bell_dptr | output | 32 | Destination pointer word |
| bell_payload | output | 32*BUF_WORDS | Outgoing payload words |
| ctl_done | input | 1 | Controller completion pulse |
| ctl_err | input | 1 | Error flag returned with completion |
| ctl_code | input | 8 | Error code returned with completion |
| ctl_reply_we | input | 1 | Reply word write enable |
| ctl_reply_idx | input | $clog2(BUF_WORDS) | Reply word index |
| ctl_reply_data | input | 32 | Reply word data |

## Verification
The bench targets a set of cycle-level collisions:
- A command write while busy. A design that re-armed on it would ring a second doorbell and overwrite the command it is serving.
- A completion pulse while idle. If honoured, it would fabricate a stale error code.
- A completion and a clearing status write in the same cycle. Getting the priority wrong loses an interrupt.
- A command issued without the interrupt request. A design that ignores bit 8 raises a spurious interrupt.
- Misaligned, unmapped and reply-buffer host writes. Decoding too few address bits would corrupt a neighbouring register.

Random traffic mixes all of these against a bench model of the register file.

// File: rtl/ipc_mbox_pkg.sv
package ipc_mbox_pkg;

    localparam int unsigned WORD_W = 32;
    localparam int unsigned CODE_W = 8;

    // Byte offsets of the host-visible registers
    localparam int unsigned OFF_CMD  = 32'h000;
    localparam int unsigned OFF_STS  = 32'h004;
    localparam int unsigned OFF_SPTR = 32'h008;
    localparam int unsigned OFF_DPTR = 32'h00C;
    localparam int unsigned OFF_WBUF = 32'h080;
    localparam int unsigned OFF_RBUF = 32'h090;

    // Field positions
    localparam int unsigned CMD_IRQ_REQ_BIT = 8;
    localparam int unsigned STS_BUSY_BIT    = 0;
    localparam int unsigned STS_ERR_BIT     = 1;
    localparam int unsigned STS_DONE_BIT    = 2;
    localparam int unsigned STS_CODE_LSB    = 16;

    typedef enum logic [CODE_W-1:0] {
        ERR_NONE         = 8'd0,
        ERR_UNSUPPORTED  = 8'd1,
        ERR_NOT_SERVICED = 8'd2,
        ERR_NO_SERVICE   = 8'd3,
        ERR_INVALID      = 8'd4,
        ERR_FAILED       = 8'd5,
        ERR_SECURITY     = 8'd6,
        ERR_UNSIGNED     = 8'd7
    } ipc_err_e;

    typedef struct packed {
        logic cmd;
        logic sts;
        logic sptr;
        logic dptr;
        logic wbuf;
        logic rbuf;
    } hit_t;

    typedef struct packed {
        logic [WORD_W-1:0] cmd;
        logic              busy;
        logic              err;
        logic [CODE_W-1:0] code;
        logic              done;
        logic              bell;
    } seq_state_t;

    function automatic logic [WORD_W-1:0] pack_status(
        input logic              busy,
        input logic              err,
        input logic              done,
        input logic [CODE_W-1:0] code
    );
        logic [WORD_W-1:0] s;
        s = '0;
        s[STS_BUSY_BIT] = busy;
        s[STS_ERR_BIT]  = err;
        s[STS_DONE_BIT] = done;
        s[STS_CODE_LSB +: CODE_W] = code;
        return s;
    endfunction

endpackage

// File: rtl/ipc_mbox_decode.sv
module ipc_mbox_decode
    import ipc_mbox_pkg::*;
#(
    parameter int unsigned ADDR_W = 12,
    parameter int unsigned NW     = 4,
    localparam int unsigned IW    = (NW > 1) ? $clog2(NW) : 1
) (
    input  logic [ADDR_W-1:0] addr_i,
    output hit_t              hit_o,
    output logic [IW-1:0]     idx_o
);

    localparam int unsigned WI_W = ADDR_W - 2;
    localparam logic [WI_W-1:0] CMD_WI  = WI_W'(OFF_CMD  >> 2);
    localparam logic [WI_W-1:0] STS_WI  = WI_W'(OFF_STS  >> 2);
    localparam logic [WI_W-1:0] SPTR_WI = WI_W'(OFF_SPTR >> 2);
    localparam logic [WI_W-1:0] DPTR_WI = WI_W'(OFF_DPTR >> 2);
    localparam logic [WI_W-1:0] WBUF_WI = WI_W'(OFF_WBUF >> 2);
    localparam logic [WI_W-1:0] RBUF_WI = WI_W'(OFF_RBUF >> 2);

    logic            aligned;
    logic [WI_W-1:0] wi;

    assign aligned = (addr_i[1:0] == 2'b00);
    assign wi      = addr_i[ADDR_W-1:2];

    always_comb begin
        hit_o      = '0;
        hit_o.cmd  = aligned && (wi == CMD_WI);
        hit_o.sts  = aligned && (wi == STS_WI);
        hit_o.sptr = aligned && (wi == SPTR_WI);
        hit_o.dptr = aligned && (wi == DPTR_WI);
        hit_o.wbuf = aligned && ((wi >> IW) == (WBUF_WI >> IW));
        hit_o.rbuf = aligned && ((wi >> IW) == (RBUF_WI >> IW));
    end

    assign idx_o = wi[IW-1:0];

endmodule

// File: rtl/ipc_mbox_bank.sv
module ipc_mbox_bank #(
    parameter int unsigned NW     = 4,
    parameter int unsigned DW     = 32,
    localparam int unsigned IW    = (NW > 1) ? $clog2(NW) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   we_i,
    input  logic [IW-1:0]          idx_i,
    input  logic [DW-1:0]          wdata_i,
    output logic [NW-1:0][DW-1:0]  words_o
);

    typedef struct packed {
        logic [NW-1:0][DW-1:0] w;
    } bank_t;

    bank_t bank_d, bank_q;

    always_comb begin
        bank_d = bank_q;
        if (we_i && (32'(idx_i) < NW)) begin
            bank_d.w[idx_i] = wdata_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bank_q <= '0;
        end else begin
            bank_q <= bank_d;
        end
    end

    assign words_o = bank_q.w;

endmodule

// File: rtl/ipc_mbox_seq.sv
module ipc_mbox_seq
    import ipc_mbox_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_wr_i,
    input  logic [WORD_W-1:0] cmd_data_i,
    input  logic              sts_clr_i,
    input  logic              done_i,
    input  logic              err_i,
    input  logic [CODE_W-1:0] code_i,
    output logic [WORD_W-1:0] cmd_o,
    output logic              busy_o,
    output logic              err_o,
    output logic [CODE_W-1:0] code_o,
    output logic              flag_o,
    output logic              bell_o,
    output logic              irq_o
);

    seq_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.bell = 1'b0;

        // Start of a transaction: only from idle
        if (cmd_wr_i && !st_q.busy) begin
            st_d.cmd  = cmd_data_i;
            st_d.busy = 1'b1;
            st_d.err  = 1'b0;
            st_d.code = '0;
            st_d.bell = 1'b1;
        end

        // Host acknowledge of the completion flag
        if (sts_clr_i) begin
            st_d.done = 1'b0;
        end

        // Completion from the controller: set wins over a same-cycle clear
        if (done_i && st_q.busy) begin
            st_d.busy = 1'b0;
            st_d.err  = err_i;
            st_d.code = code_i;
            st_d.done = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cmd_o  = st_q.cmd;
    assign busy_o = st_q.busy;
    assign err_o  = st_q.err;
    assign code_o = st_q.code;
    assign flag_o = st_q.done;
    assign bell_o = st_q.bell;
    assign irq_o  = st_q.done & st_q.cmd[CMD_IRQ_REQ_BIT];

endmodule

// File: rtl/ipc_mbox_rdmux.sv
module ipc_mbox_rdmux
    import ipc_mbox_pkg::*;
#(
    parameter int unsigned NW  = 4,
    localparam int unsigned IW = (NW > 1) ? $clog2(NW) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      rd_i,
    input  hit_t                      hit_i,
    input  logic [IW-1:0]             idx_i,
    input  logic [WORD_W-1:0]         cmd_i,
    input  logic [WORD_W-1:0]         status_i,
    input  logic [WORD_W-1:0]         sptr_i,
    input  logic [WORD_W-1:0]         dptr_i,
    input  logic [NW-1:0][WORD_W-1:0] wbuf_i,
    input  logic [NW-1:0][WORD_W-1:0] rbuf_i,
    output logic [WORD_W-1:0]         rdata_o
);

    logic [WORD_W-1:0] sel;
    logic [WORD_W-1:0] rdata_d, rdata_q;

    always_comb begin
        sel = '0;
        if (hit_i.cmd) begin
            sel = cmd_i;
        end else if (hit_i.sts) begin
            sel = status_i;
        end else if (hit_i.sptr) begin
            sel = sptr_i;
        end else if (hit_i.dptr) begin
            sel = dptr_i;
        end else if (hit_i.wbuf) begin
            sel = wbuf_i[idx_i];
        end else if (hit_i.rbuf) begin
            sel = rbuf_i[idx_i];
        end
    end

    always_comb begin
        rdata_d = rdata_q;
        if (rd_i) begin
            rdata_d = sel;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else begin
            rdata_q <= rdata_d;
        end
    end

    assign rdata_o = rdata_q;

endmodule

// File: rtl/ipc_mailbox.sv
module ipc_mailbox
    import ipc_mbox_pkg::*;
#(
    parameter int unsigned ADDR_W    = 12,
    parameter int unsigned BUF_WORDS = 4,
    localparam int unsigned IW       = (BUF_WORDS > 1) ? $clog2(BUF_WORDS) : 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [ADDR_W-1:0]           host_addr,
    input  logic                        host_wr,
    input  logic                        host_rd,
    input  logic [WORD_W-1:0]           host_wdata,
    output logic [WORD_W-1:0]           host_rdata,
    output logic                        host_irq,
    output logic                        bell_valid,
    output logic [WORD_W-1:0]           bell_cmd,
    output logic [WORD_W-1:0]           bell_sptr,
    output logic [WORD_W-1:0]           bell_dptr,
    output logic [WORD_W*BUF_WORDS-1:0] bell_payload,
    input  logic                        ctl_done,
    input  logic                        ctl_err,
    input  logic [CODE_W-1:0]           ctl_code,
    input  logic                        ctl_reply_we,
    input  logic [IW-1:0]               ctl_reply_idx,
    input  logic [WORD_W-1:0]           ctl_reply_data
);

    hit_t                             hit;
    logic [IW-1:0]                    buf_idx;
    logic                             cmd_wr;
    logic                             sts_wr;
    logic                             sts_clr;
    logic                             st_busy;
    logic                             st_err;
    logic                             st_flag;
    logic [CODE_W-1:0]                st_code;
    logic [WORD_W-1:0]                status_word;
    logic [1:0][WORD_W-1:0]           ptr_words;
    logic [BUF_WORDS-1:0][WORD_W-1:0] wbuf_words;
    logic [BUF_WORDS-1:0][WORD_W-1:0] rbuf_words;

    ipc_mbox_decode #(
        .ADDR_W (ADDR_W),
        .NW     (BUF_WORDS)
    ) u_decode (
        .addr_i (host_addr),
        .hit_o  (hit),
        .idx_o  (buf_idx)
    );

    assign cmd_wr  = host_wr & hit.cmd;
    assign sts_wr  = host_wr & hit.sts;
    assign sts_clr = sts_wr & host_wdata[STS_DONE_BIT];

    ipc_mbox_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_wr_i   (cmd_wr),
        .cmd_data_i (host_wdata),
        .sts_clr_i  (sts_clr),
        .done_i     (ctl_done),
        .err_i      (ctl_err),
        .code_i     (ctl_code),
        .cmd_o      (bell_cmd),
        .busy_o     (st_busy),
        .err_o      (st_err),
        .code_o     (st_code),
        .flag_o     (st_flag),
        .bell_o     (bell_valid),
        .irq_o      (host_irq)
    );

    // Pointer words: index 0 is the source, index 1 the destination
    ipc_mbox_bank #(
        .NW (2),
        .DW (WORD_W)
    ) u_ptr_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (host_wr & (hit.sptr | hit.dptr)),
        .idx_i   (hit.dptr),
        .wdata_i (host_wdata),
        .words_o (ptr_words)
    );

    ipc_mbox_bank #(
        .NW (BUF_WORDS),
        .DW (WORD_W)
    ) u_out_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (host_wr & hit.wbuf),
        .idx_i   (buf_idx),
        .wdata_i (host_wdata),
        .words_o (wbuf_words)
    );

    ipc_mbox_bank #(
        .NW (BUF_WORDS),
        .DW (WORD_W)
    ) u_reply_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (ctl_reply_we),
        .idx_i   (ctl_reply_idx),
        .wdata_i (ctl_reply_data),
        .words_o (rbuf_words)
    );

    assign status_word  = pack_status(st_busy, st_err, st_flag, st_code);
    assign bell_sptr    = ptr_words[0];
    assign bell_dptr    = ptr_words[1];
    assign bell_payload = wbuf_words;

    ipc_mbox_rdmux #(
        .NW (BUF_WORDS)
    ) u_rdmux (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_i     (host_rd),
        .hit_i    (hit),
        .idx_i    (buf_idx),
        .cmd_i    (bell_cmd),
        .status_i (status_word),
        .sptr_i   (ptr_words[0]),
        .dptr_i   (ptr_words[1]),
        .wbuf_i   (wbuf_words),
        .rbuf_i   (rbuf_words),
        .rdata_o  (host_rdata)
    );

endmodule

// File: rtl/ipc_mbox_checker.sv
module ipc_mbox_checker
    import ipc_mbox_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_wr,
    input logic              sts_wr,
    input logic              sts_clr,
    input logic              ctl_done,
    input logic              ctl_err,
    input logic [CODE_W-1:0] ctl_code,
    input logic              busy,
    input logic              err,
    input logic              flag,
    input logic [CODE_W-1:0] code,
    input logic              bell_valid,
    input logic [WORD_W-1:0] bell_cmd,
    input logic              irq
);

    p_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && !busy) |=> (busy && bell_valid));

    p_bell_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        bell_valid |=> !bell_valid);

    p_no_second_bell_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && busy) |=> !bell_valid);

    p_cmd_kept_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && busy) |=> $stable(bell_cmd));

    p_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_done && busy) |=> (!busy && flag));

    p_err_capture_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_done && busy) |=> (err == $past(ctl_err) && code == $past(ctl_code)));

    p_idle_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_done && !busy && !cmd_wr) |=> ($stable(err) && $stable(code)));

    p_err_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && !busy) |=> (!err && code == '0));

    p_irq_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (flag && bell_cmd[CMD_IRQ_REQ_BIT]));

    p_flag_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_clr && !(ctl_done && busy)) |=> !flag);

    p_flag_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_wr && !sts_clr && flag) |=> flag);

endmodule

bind ipc_mailbox ipc_mbox_checker u_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_wr     (cmd_wr),
    .sts_wr     (sts_wr),
    .sts_clr    (sts_clr),
    .ctl_done   (ctl_done),
    .ctl_err    (ctl_err),
    .ctl_code   (ctl_code),
    .busy       (st_busy),
    .err        (st_err),
    .flag       (st_flag),
    .code       (st_code),
    .bell_valid (bell_valid),
    .bell_cmd   (bell_cmd),
    .irq        (host_irq)
);

// File: tb/ipc_mailbox_tb_top.sv
module ipc_mailbox_tb_top;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [11:0]  host_addr = '0;
    logic         host_wr = 1'b0;
    logic         host_rd = 1'b0;
    logic [31:0]  host_wdata = '0;
    logic [31:0]  host_rdata;
    logic         host_irq;
    logic         bell_valid;
    logic [31:0]  bell_cmd, bell_sptr, bell_dptr;
    logic [127:0] bell_payload;
    logic         ctl_done = 1'b0;
    logic         ctl_err = 1'b0;
    logic [7:0]   ctl_code = '0;
    logic         ctl_reply_we = 1'b0;
    logic [1:0]   ctl_reply_idx = '0;
    logic [31:0]  ctl_reply_data = '0;

    always #5 clk = ~clk;

    ipc_mailbox dut_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .host_addr      (host_addr),
        .host_wr        (host_wr),
        .host_rd        (host_rd),
        .host_wdata     (host_wdata),
        .host_rdata     (host_rdata),
        .host_irq       (host_irq),
        .bell_valid     (bell_valid),
        .bell_cmd       (bell_cmd),
        .bell_sptr      (bell_sptr),
        .bell_dptr      (bell_dptr),
        .bell_payload   (bell_payload),
        .ctl_done       (ctl_done),
        .ctl_err        (ctl_err),
        .ctl_code       (ctl_code),
        .ctl_reply_we   (ctl_reply_we),
        .ctl_reply_idx  (ctl_reply_idx),
        .ctl_reply_data (ctl_reply_data)
    );

    int n_chk  = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    // Bench model of the register file
    logic [31:0] m_cmd = '0, m_sptr = '0, m_dptr = '0;
    logic        m_busy = 1'b0, m_err = 1'b0, m_flag = 1'b0;
    logic [7:0]  m_code = '0;
    logic [31:0] m_wbuf [4];
    logic [31:0] m_rbuf [4];
    logic [31:0] last_rd = '0;

    task automatic chk(input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_read(input logic [11:0] a);
        logic [31:0] v;
        v = '0;
        case (a)
            12'h000: v = m_cmd;
            12'h004: v = {8'h00, m_code, 13'h0, m_flag, m_err, m_busy};
            12'h008: v = m_sptr;
            12'h00C: v = m_dptr;
            12'h080, 12'h084, 12'h088, 12'h08C: v = m_wbuf[a[3:2]];
            12'h090, 12'h094, 12'h098, 12'h09C: v = m_rbuf[a[3:2]];
            default: v = '0;
        endcase
        return v;
    endfunction

    function automatic string tag_of(input logic [11:0] a);
        case (a)
            12'h004: return "R4";
            12'h000, 12'h008, 12'h00C,
            12'h080, 12'h084, 12'h088, 12'h08C: return "R8";
            12'h090, 12'h094, 12'h098, 12'h09C: return "R9";
            default: return "R10";
        endcase
    endfunction

    // One transaction cycle: drive at a falling edge, check at the next one
    task automatic step(input logic hw, input logic hr, input logic [11:0] a,
                        input logic [31:0] d, input logic dn, input logic er,
                        input logic [7:0] cd, input logic rwe,
                        input logic [1:0] ri, input logic [31:0] rdv);
        logic acc, pb, is_cmd;
        @(negedge clk);
        host_wr = hw; host_rd = hr; host_addr = a; host_wdata = d;
        ctl_done = dn; ctl_err = er; ctl_code = cd;
        ctl_reply_we = rwe; ctl_reply_idx = ri; ctl_reply_data = rdv;
        is_cmd = hw && (a == 12'h000);
        acc    = is_cmd && !m_busy;
        pb     = m_busy;
        if (hr) last_rd = exp_read(a);
        if (rwe) m_rbuf[ri] = rdv;
        if (hw) begin
            case (a)
                12'h008: m_sptr = d;
                12'h00C: m_dptr = d;
                12'h080, 12'h084, 12'h088, 12'h08C: m_wbuf[a[3:2]] = d;
                default: ;
            endcase
        end
        if (acc) begin
            m_cmd = d; m_busy = 1'b1; m_err = 1'b0; m_code = '0;
        end
        if (hw && (a == 12'h004) && d[2]) m_flag = 1'b0;
        if (dn && pb) begin
            m_busy = 1'b0; m_err = er; m_code = cd; m_flag = 1'b1;
        end
        @(negedge clk);
        host_wr = 1'b0; host_rd = 1'b0; ctl_done = 1'b0; ctl_reply_we = 1'b0;
        chk(is_cmd ? (acc ? "R2" : "R3") : "R2", "bell_valid", bell_valid, acc);
        if (acc) begin
            chk("R2", "bell_cmd", bell_cmd, m_cmd);
            chk("R2", "bell_sptr", bell_sptr, m_sptr);
            chk("R2", "bell_dptr", bell_dptr, m_dptr);
            chk("R2", "bell_payload", bell_payload,
                {m_wbuf[3], m_wbuf[2], m_wbuf[1], m_wbuf[0]});
        end
        if (is_cmd && !acc) chk("R3", "bell_cmd kept", bell_cmd, m_cmd);
        chk(hr ? tag_of(a) : "R11", "host_rdata", host_rdata, last_rd);
        chk("R6", "host_irq", host_irq, m_flag && m_cmd[8]);
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        step(1'b1, 1'b0, a, d, 1'b0, 1'b0, 8'h0, 1'b0, 2'd0, 32'h0);
    endtask
    task automatic rd(input logic [11:0] a);
        step(1'b0, 1'b1, a, 32'h0, 1'b0, 1'b0, 8'h0, 1'b0, 2'd0, 32'h0);
    endtask
    task automatic done(input logic e, input logic [7:0] c);
        step(1'b0, 1'b0, 12'h0, 32'h0, 1'b1, e, c, 1'b0, 2'd0, 32'h0);
    endtask
    task automatic reply(input logic [1:0] i, input logic [31:0] v);
        step(1'b0, 1'b0, 12'h0, 32'h0, 1'b0, 1'b0, 8'h0, 1'b1, i, v);
    endtask

    function automatic logic [11:0] pick_addr();
        case ($urandom_range(0, 9))
            0: return 12'h000;
            1: return 12'h004;
            2: return 12'h008;
            3: return 12'h00C;
            4: return 12'h080 | 12'({$urandom_range(0, 3), 2'b00});
            5: return 12'h090 | 12'({$urandom_range(0, 3), 2'b00});
            6: return 12'h010;
            7: return 12'h081;
            8: return 12'h0A0;
            default: return 12'($urandom);
        endcase
    endfunction

    initial begin
        repeat (60000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL R1 watchdog act=running exp=finished");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] seed_sink;
        seed_sink = $urandom(32'h5EED1);
        for (int i = 0; i < 4; i++) begin
            m_wbuf[i] = '0;
            m_rbuf[i] = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1", "irq", host_irq, 1'b0);
        chk("R1", "bell", bell_valid, 1'b0);
        chk("R1", "rdata", host_rdata, 32'h0);
        rd(12'h004);
        chk("R1", "status", host_rdata, 32'h0);
        rd(12'h000);
        chk("R1", "cmd", host_rdata, 32'h0);

        // R8: pointers and payload
        wr(12'h008, 32'hA5A5_0001);
        wr(12'h00C, 32'h5A5A_0002);
        for (int i = 0; i < 4; i++) wr(12'(12'h080 + 4 * i), 32'hC0DE_0000 + i);
        rd(12'h008);
        chk("R8", "sptr", host_rdata, 32'hA5A5_0001);
        rd(12'h08C);
        chk("R8", "wbuf3", host_rdata, 32'hC0DE_0003);

        // R2: command with interrupt request
        wr(12'h000, 32'h0004_3105);
        rd(12'h004);
        chk("R2", "status busy", host_rdata, 32'h0000_0001);
        // R3: write while busy
        wr(12'h000, 32'h0000_00FF);
        rd(12'h000);
        chk("R3", "cmd kept", host_rdata, 32'h0004_3105);

        // R9 and R4
        reply(2'd0, 32'h1111_0000);
        reply(2'd3, 32'h3333_0000);
        done(1'b1, 8'd6);
        rd(12'h004);
        chk("R4", "status done", host_rdata, 32'h0006_0006);
        chk("R6", "irq set", host_irq, 1'b1);
        rd(12'h09C);
        chk("R9", "rbuf3", host_rdata, 32'h3333_0000);
        // R4: completion while idle ignored
        done(1'b0, 8'd3);
        rd(12'h004);
        chk("R4", "idle done", host_rdata, 32'h0006_0006);
        // R7: bit 2 clear keeps flag, bit 2 set clears
        wr(12'h004, 32'h0000_0003);
        chk("R7", "flag kept", host_irq, 1'b1);
        wr(12'h004, 32'h0000_0004);
        chk("R7", "flag cleared", host_irq, 1'b0);

        // R5 and R6: new command without interrupt request
        wr(12'h000, 32'h0000_0022);
        rd(12'h004);
        chk("R5", "err cleared", host_rdata, 32'h0000_0001);
        done(1'b0, 8'd0);
        chk("R6", "no irq", host_irq, 1'b0);

        // R10: writes to reply buffer, unmapped and misaligned offsets
        wr(12'h090, 32'hDEAD_BEEF);
        wr(12'h010, 32'hDEAD_BEEF);
        wr(12'h009, 32'hDEAD_BEEF);
        rd(12'h090);
        chk("R10", "rbuf untouched", host_rdata, 32'h1111_0000);
        rd(12'h008);
        chk("R10", "sptr untouched", host_rdata, 32'hA5A5_0001);
        rd(12'h010);
        chk("R10", "unmapped", host_rdata, 32'h0);

        // R7: completion and clear in the same cycle
        wr(12'h000, 32'h0000_0101);
        step(1'b1, 1'b0, 12'h004, 32'h4, 1'b1, 1'b0, 8'd0, 1'b0, 2'd0, 32'h0);
        chk("R7", "set wins", host_irq, 1'b1);

        // Constrained random traffic
        for (int n = 0; n < 1500; n++) begin
            int op;
            logic [11:0] a;
            op = $urandom_range(0, 9);
            a  = pick_addr();
            case (op)
                0: wr(12'h000, {8'h0, 8'($urandom), 4'($urandom), 3'b0,
                                1'($urandom), 8'($urandom)});
                1: wr(a, $urandom);
                2: wr(12'h004, {29'($urandom), 1'($urandom), 2'b00});
                3: done(1'($urandom), 8'($urandom_range(0, 7)));
                4: reply(2'($urandom), $urandom);
                5, 6: rd(a);
                7: wr(12'h090 | 12'({$urandom_range(0, 7), 2'b00}), $urandom);
                8: step(1'b1, 1'b0, 12'h004, 32'h4, 1'b1, 1'($urandom),
                        8'($urandom), 1'b0, 2'd0, 32'h0);
                default: step(1'b0, 1'b1, a, 32'h0, 1'b0, 1'b0, 8'h0,
                              1'b1, 2'($urandom), $urandom);
            endcase
        end

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule